// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block raises software interrupts between up to eight processors, each with sixteen software interrupt numbers. A processor writes a request word into the generation register. The block turns the word into a set of destination processors. For every destination it latches the interrupt as pending and records which processor asked for it. Each (destination, interrupt number) cell keeps an 8-bit mask of requesting processors. The cell stays pending as long as any bit in its mask is set.

Software can also edit the masks directly through two 16-byte windows, one that ORs bits in and one that removes them. Both windows are banked: an access touches only the cells of the processor named on `req_cpu_i`.

The block drives a flat pending vector and a one-cycle queue pulse per processor. A downstream prioritiser uses these to schedule delivery.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source mask is zero, every pending bit is low and `queue_o` is zero.
- R2: A generation write with mode 0 (word bits [25:24]) selects the processors in the list field (bits [23:16]). List bits at or above `online_cnt_i` are dropped.
- R3: Mode 1 selects every processor below `online_cnt_i` except the requester.
- R4: Mode 2 selects only the requester.
- R5: Mode 3 is reserved. The whole write changes no state and raises no queue pulse.
- R6: For each selected processor, the cell addressed by word bits [3:0] ORs in bit `req_cpu_i` of its source mask and becomes pending. That processor's `queue_o` bit is high for exactly the cycle after the write.
- R7: Address bits [5:4] select the region: 00 generation, 01 clear window, 10 set window, 11 unused. Reads of regions 00 and 11 return zero, and writes to region 11 have no effect.
- R8: A clear-window write removes the written ones from the mask. Pending drops only when the mask becomes zero. A clear-window write never raises a queue pulse.
- R9: A set-window write ORs the written bits into the mask. If the resulting mask is nonzero, the cell goes pending and the accessing processor's queue bit pulses in the next cycle. If the mask stays zero, nothing changes.
- R10: With `bus_word_i` low, only byte lane 0 is used and it addresses interrupt `addr[3:0]`. With `bus_word_i` high, lane i (data bits [8i+7:8i]) addresses interrupt `{addr[3:2],2'b00}+i`.
- R11: Window reads and writes reach only the cells whose destination is `req_cpu_i`. Cells of other processors are untouched.
- R12: A window read returns, in the same cycle, each addressed lane's source mask. Unused lanes read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| online_cnt_i | input | 4 | Number of processors currently online (1..8) |
| req_cpu_i | input | 3 | Identity of the processor making the access |
| bus_en_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr_i | input | 6 | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pend_o | output | 128 | Pending bits, index cpu*16+id |
| queue_o | output | 8 | One-cycle delivery request per processor |

## Verification
The assertions assume that `online_cnt_i` lies between 1 and the processor count and that `req_cpu_i` names an online processor. They also assume every word access is aligned on a four-byte boundary. Under those assumptions the filter-mode checks can relate the queue pulse directly to the sampled requester and online count. The stimulus generator meets each assumption by construction. It draws the online count first, then a requester below it, and it clears the two low address bits whenever it picks a word access. Directed sequences build up overlapping masks from several requesters, so the clear path is exercised both when pending must stay up and when it must drop.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_RSVD   = 2'd3
  } filt_e;

  typedef enum logic [1:0] {
    RGN_GEN  = 2'd0,
    RGN_CLR  = 2'd1,
    RGN_SET  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  localparam int GEN_ID_LSB   = 0;
  localparam int GEN_LIST_LSB = 16;
  localparam int GEN_MODE_LSB = 24;
  localparam int LANE_W       = 8;

endpackage

// File: rtl/sgi_target_decode.sv
`timescale 1ns/1ps
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int ID_W     = 4,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = $clog2(NUM_CPUS),
  localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   word_i,
  input  logic [CPU_W-1:0]    req_i,
  input  logic [CNT_W-1:0]    online_i,
  output logic [NUM_CPUS-1:0] hit_o,
  output logic [ID_W-1:0]     id_o
);

  logic [NUM_CPUS-1:0] online_msk;
  logic [NUM_CPUS-1:0] self_oh;
  logic [NUM_CPUS-1:0] list;
  logic [NUM_CPUS-1:0] sel;
  filt_e               mode;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_online
    assign online_msk[c] = CNT_W'(c) < online_i;
  end

  assign self_oh = NUM_CPUS'(1) << req_i;
  assign list    = word_i[GEN_LIST_LSB +: NUM_CPUS];
  assign mode    = filt_e'(word_i[GEN_MODE_LSB +: 2]);
  assign id_o    = word_i[GEN_ID_LSB +: ID_W];

  always_comb begin
    unique case (mode)
      FILT_LIST:   sel = list & online_msk;
      FILT_OTHERS: sel = online_msk & ~self_oh;
      FILT_SELF:   sel = self_oh;
      default:     sel = '0;
    endcase
  end

  assign hit_o = wr_i ? sel : '0;

  logic unused_fields;
  assign unused_fields = ^{word_i[GEN_LIST_LSB-1:ID_W],
                           word_i[DATA_W-1:GEN_MODE_LSB+2],
                           word_i[GEN_MODE_LSB-1:GEN_LIST_LSB+NUM_CPUS]};

endmodule

// File: rtl/sgi_lane_map.sv
`timescale 1ns/1ps
module sgi_lane_map
  import sgi_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int DATA_W  = 32,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int LANES  = DATA_W / LANE_W,
  localparam int LB_W   = $clog2(LANES)
) (
  input  logic                              en_i,
  input  logic                              word_i,
  input  logic [ID_W-1:0]                   offset_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_IDS-1:0][LANE_W-1:0]    src_i,
  output logic [NUM_IDS-1:0]                hit_o,
  output logic [NUM_IDS-1:0][LANE_W-1:0]    data_o,
  output logic [DATA_W-1:0]                 rdata_o
);

  logic [ID_W-1:0] base;

  // word accesses snap to the lane-aligned group of IDs
  assign base = word_i ? ((offset_i >> LB_W) << LB_W) : offset_i;

  always_comb begin
    hit_o   = '0;
    data_o  = '0;
    rdata_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i == 0 || word_i) begin
        hit_o[base + ID_W'(i)]        = en_i;
        data_o[base + ID_W'(i)]       = wdata_i[i*LANE_W +: LANE_W];
        rdata_o[i*LANE_W +: LANE_W]   = src_i[base + ID_W'(i)];
      end
    end
  end

endmodule

// File: rtl/sgi_cell.sv
`timescale 1ns/1ps
module sgi_cell #(
  parameter int SRC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gen_hit_i,
  input  logic [SRC_W-1:0] gen_src_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [SRC_W-1:0] bits_i,
  output logic [SRC_W-1:0] src_o,
  output logic             pend_o,
  output logic             queue_o
);

  logic [SRC_W-1:0] src_q, src_d;
  logic             pend_q, pend_d;

  always_comb begin
    src_d = src_q;
    if (clr_we_i) src_d = src_d & ~bits_i;
    if (set_we_i) src_d = src_d | bits_i;
    // generation applied last
    if (gen_hit_i) src_d = src_d | gen_src_i;

    pend_d = pend_q;
    if (clr_we_i && src_d == '0) pend_d = 1'b0;
    if (set_we_i && src_d != '0) pend_d = 1'b1;
    if (gen_hit_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  assign src_o   = src_q;
  assign pend_o  = pend_q;
  assign queue_o = gen_hit_i | (set_we_i && src_d != '0);

endmodule

// File: rtl/sgi_dispatch.sv
`timescale 1ns/1ps
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IDS  = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = $clog2(NUM_CPUS),
  localparam int CNT_W   = $clog2(NUM_CPUS + 1),
  localparam int ID_W    = $clog2(NUM_IDS),
  localparam int SRC_W   = NUM_CPUS,
  localparam int CELLS   = NUM_CPUS * NUM_IDS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    online_cnt_i,
  input  logic [CPU_W-1:0]    req_cpu_i,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic                bus_word_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [CELLS-1:0]    pend_o,
  output logic [NUM_CPUS-1:0] queue_o
);

  rgn_e                                 rgn;
  logic                                 wr, gen_wr, set_wr, clr_wr, win_rd;
  logic [NUM_CPUS-1:0]                  tgt_hit;
  logic [ID_W-1:0]                      gen_id;
  logic [SRC_W-1:0]                     gen_src;
  logic [NUM_IDS-1:0]                   win_hit;
  logic [NUM_IDS-1:0][LANE_W-1:0]       win_data;
  logic [NUM_IDS-1:0][LANE_W-1:0]       bank_src;
  logic [DATA_W-1:0]                    win_rdata;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0][SRC_W-1:0] src_mat;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]     queue_req;
  logic [NUM_CPUS-1:0]                  queue_d, queue_q;
  logic [CELLS*SRC_W-1:0]               src_all;

  assign rgn    = rgn_e'(bus_addr_i[ADDR_W-1 -: 2]);
  assign wr     = bus_en_i & bus_we_i;
  assign gen_wr = wr && rgn == RGN_GEN;
  assign set_wr = wr && rgn == RGN_SET;
  assign clr_wr = wr && rgn == RGN_CLR;
  assign win_rd = bus_en_i && !bus_we_i && (rgn == RGN_SET || rgn == RGN_CLR);

  sgi_target_decode #(
    .NUM_CPUS (NUM_CPUS),
    .ID_W     (ID_W),
    .DATA_W   (DATA_W)
  ) u_decode (
    .wr_i     (gen_wr),
    .word_i   (bus_wdata_i),
    .req_i    (req_cpu_i),
    .online_i (online_cnt_i),
    .hit_o    (tgt_hit),
    .id_o     (gen_id)
  );

  assign gen_src = SRC_W'(1) << req_cpu_i;

  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) begin
      bank_src[i] = LANE_W'(src_mat[req_cpu_i][i]);
    end
  end

  sgi_lane_map #(
    .NUM_IDS (NUM_IDS),
    .DATA_W  (DATA_W)
  ) u_lanes (
    .en_i     (bus_en_i),
    .word_i   (bus_word_i),
    .offset_i (bus_addr_i[ID_W-1:0]),
    .wdata_i  (bus_wdata_i),
    .src_i    (bank_src),
    .hit_o    (win_hit),
    .data_o   (win_data),
    .rdata_o  (win_rdata)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic is_bank;
    assign is_bank = req_cpu_i == CPU_W'(c);
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      sgi_cell #(.SRC_W(SRC_W)) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .gen_hit_i (tgt_hit[c] && gen_id == ID_W'(i)),
        .gen_src_i (gen_src),
        .set_we_i  (set_wr && is_bank && win_hit[i]),
        .clr_we_i  (clr_wr && is_bank && win_hit[i]),
        .bits_i    (win_data[i][SRC_W-1:0]),
        .src_o     (src_mat[c][i]),
        .pend_o    (pend_o[c*NUM_IDS + i]),
        .queue_o   (queue_req[c][i])
      );
      assign src_all[(c*NUM_IDS + i)*SRC_W +: SRC_W] = src_mat[c][i];
    end
    assign queue_d[c] = |queue_req[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) queue_q <= '0;
    else         queue_q <= queue_d;
  end

  assign queue_o = queue_q;
  assign rdata_o = win_rd ? win_rdata : '0;

endmodule

// File: rtl/sgi_dispatch_chk.sv
`timescale 1ns/1ps
module sgi_dispatch_chk #(
  parameter int NUM_CPUS = 8,
  parameter int NUM_IDS  = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = $clog2(NUM_CPUS),
  localparam int CNT_W   = $clog2(NUM_CPUS + 1),
  localparam int SRC_W   = NUM_CPUS,
  localparam int CELLS   = NUM_CPUS * NUM_IDS
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CNT_W-1:0]       online_cnt_i,
  input logic [CPU_W-1:0]       req_cpu_i,
  input logic                   bus_en_i,
  input logic                   bus_we_i,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic [DATA_W-1:0]      bus_wdata_i,
  input logic [DATA_W-1:0]      rdata_o,
  input logic [CELLS-1:0]       pend_o,
  input logic [NUM_CPUS-1:0]    queue_o,
  input logic [CELLS*SRC_W-1:0] src_all
);

  logic [1:0] rgn, mode;
  logic       gen_wr, clr_wr, quiet_rd;

  assign rgn      = bus_addr_i[ADDR_W-1 -: 2];
  assign mode     = bus_wdata_i[25:24];
  assign gen_wr   = bus_en_i && bus_we_i && rgn == 2'd0;
  assign clr_wr   = bus_en_i && bus_we_i && rgn == 2'd1;
  assign quiet_rd = bus_en_i && !bus_we_i && (rgn == 2'd0 || rgn == 2'd3);

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    // R8
    pend_src_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_o[k] == (src_all[k*SRC_W +: SRC_W] != '0));
  end

  // R2
  list_online_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd0 |=> (queue_o >> $past(online_cnt_i)) == '0);

  // R3
  others_skip_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd1 |=> !queue_o[$past(req_cpu_i)]);

  // R4
  self_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd2 |=> queue_o == (NUM_CPUS'(1) << $past(req_cpu_i)));

  // R5
  reserved_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_wr && mode == 2'd3 |=> queue_o == '0 && $stable(src_all));

  // R7
  quiet_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_rd |-> rdata_o == '0);

  // R8
  clear_no_queue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> queue_o == '0);

endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NUM_CPUS (NUM_CPUS),
  .NUM_IDS  (NUM_IDS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/sgi_dispatch_test.sv
`timescale 1ns/1ps
module sgi_dispatch_test;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   online_cnt_i = 4'd5;
  logic [2:0]   req_cpu_i = '0;
  logic         bus_en_i = 1'b0;
  logic         bus_we_i = 1'b0;
  logic         bus_word_i = 1'b0;
  logic [5:0]   bus_addr_i = '0;
  logic [31:0]  bus_wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] pend_o;
  logic [7:0]   queue_o;

  int n_chk = 0;
  int n_fail = 0;

  int unsigned m_src [8][16];
  bit          m_pend[8][16];
  bit [7:0]    exp_q;

  always #2 clk = ~clk;

  sgi_dispatch uut (
    .clk_i (clk), .rst_ni (rst_ni), .online_cnt_i (online_cnt_i),
    .req_cpu_i (req_cpu_i), .bus_en_i (bus_en_i), .bus_we_i (bus_we_i),
    .bus_word_i (bus_word_i), .bus_addr_i (bus_addr_i), .bus_wdata_i (bus_wdata_i),
    .rdata_o (rdata_o), .pend_o (pend_o), .queue_o (queue_o)
  );

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] model_pend();
    logic [127:0] v = '0;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++) v[c*16+i] = m_pend[c][i];
    return v;
  endfunction

  function automatic logic [31:0] model_read(logic [5:0] a, bit word, int r);
    logic [31:0] v = '0;
    int base = word ? (a & 6'hC) : (a & 6'hF);
    if (a[5:4] == 2'd1 || a[5:4] == 2'd2)
      for (int i = 0; i < (word ? 4 : 1); i++) v[i*8 +: 8] = m_src[r][base+i] & 8'hFF;
    return v;
  endfunction

  function automatic void model_write(logic [5:0] a, bit word, logic [31:0] w, int r, int onl);
    int md = w[25:24];
    int id = w[3:0];
    int base = word ? (a & 6'hC) : (a & 6'hF);
    if (a[5:4] == 2'd0) begin
      for (int c = 0; c < 8; c++) begin
        bit s = (md == 0 && w[16+c] && c < onl) || (md == 1 && c < onl && c != r) ||
                (md == 2 && c == r);
        if (s) begin
          m_src[c][id] |= (1 << r);
          m_pend[c][id] = 1;
          exp_q[c] = 1;
        end
      end
    end else if (a[5:4] == 2'd1 || a[5:4] == 2'd2) begin
      for (int i = 0; i < (word ? 4 : 1); i++) begin
        int unsigned v = (w >> (8*i)) & 8'hFF;
        if (a[5:4] == 2'd1) begin
          m_src[r][base+i] &= ~v;
          if (m_src[r][base+i] == 0) m_pend[r][base+i] = 0;
        end else begin
          m_src[r][base+i] |= v;
          if (m_src[r][base+i] != 0) begin
            m_pend[r][base+i] = 1;
            exp_q[r] = 1;
          end
        end
      end
    end
  endfunction

  task automatic compare_state(string tag);
    chk(tag, "pend_o", pend_o, model_pend());
    chk(tag, "queue_o", {120'b0, queue_o}, {120'b0, exp_q});
    exp_q = '0;
  endtask

  task automatic op(string tag, bit we, logic [5:0] a, bit word, logic [31:0] w, int r);
    @(negedge clk);
    bus_en_i = 1'b1; bus_we_i = we; bus_word_i = word;
    bus_addr_i = a; bus_wdata_i = w; req_cpu_i = 3'(r);
    #1;
    if (!we) chk(tag, "rdata_o", {96'b0, rdata_o}, {96'b0, model_read(a, word, r)});
    else model_write(a, word, w, r, int'(online_cnt_i));
    @(posedge clk); #1;
    bus_en_i = 1'b0; bus_we_i = 1'b0;
    compare_state(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    @(posedge clk); #1;
    compare_state(tag);
  endtask

  function automatic logic [31:0] gw(int md, int tl, int id);
    return {6'b0, 2'(md), 8'(tl), 12'b0, 4'(id)};
  endfunction

  function automatic string tag_of(bit we, logic [5:0] a, logic [31:0] w);
    if (!we) return (a[5:4] == 2'd1 || a[5:4] == 2'd2) ? "R12" : "R7";
    case (a[5:4])
      2'd0: case (w[25:24]) 2'd0: return "R2"; 2'd1: return "R3";
                            2'd2: return "R4"; default: return "R5"; endcase
      2'd1: return "R8";
      2'd2: return "R9";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 16; i++) begin m_src[c][i] = 0; m_pend[c][i] = 0; end
    exp_q = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pend_o in reset", pend_o, '0);
    rst_ni = 1'b1;
    idle("R1");

    // R2: list with bits above online count
    op("R2", 1, 6'h00, 1, gw(0, 8'hFF, 3), 1);
    // R3: all online but requester
    op("R3", 1, 6'h00, 1, gw(1, 0, 5), 2);
    // R4: requester only
    op("R4", 1, 6'h00, 1, gw(2, 8'hFF, 7), 4);
    // R5: reserved mode ignored
    op("R5", 1, 6'h00, 1, gw(3, 8'hFF, 3), 0);
    idle("R5");
    // R6: second requester accumulates into same mask
    op("R6", 1, 6'h00, 1, gw(0, 8'h01, 3), 3);
    op("R6", 0, 6'h10, 1, 32'h0, 0);
    // R7: quiet regions
    op("R7", 0, 6'h00, 1, 32'h0, 0);
    op("R7", 0, 6'h30, 1, 32'h0, 0);
    op("R7", 1, 6'h34, 1, 32'hFFFF_FFFF, 0);
    // R8: partial clear keeps pending, full clear drops it
    op("R8", 1, 6'h13, 0, 32'h02, 0);
    op("R8", 0, 6'h13, 0, 32'h0, 0);
    op("R8", 1, 6'h13, 0, 32'h08, 0);
    // R9: set window, zero on empty, zero on nonzero
    op("R9", 1, 6'h29, 0, 32'h40, 2);
    op("R9", 1, 6'h2A, 0, 32'h00, 2);
    op("R9", 1, 6'h29, 0, 32'h00, 2);
    // R10: word lanes then byte reads
    op("R10", 1, 6'h24, 1, 32'h0403_0201, 1);
    op("R10", 0, 6'h16, 0, 32'h0, 1);
    op("R10", 0, 6'h14, 1, 32'h0, 1);
    // R11: other bank sees its own masks only
    op("R11", 0, 6'h24, 1, 32'h0, 3);
    op("R11", 1, 6'h14, 1, 32'hFFFF_FFFF, 3);
    op("R11", 0, 6'h24, 1, 32'h0, 1);
    // R12: word read across mixed masks
    op("R12", 0, 6'h18, 1, 32'h0, 2);

    for (int n = 0; n < 400; n++) begin
      int onl = 1 + ($urandom % 8);
      int r = $urandom % onl;
      bit we = ($urandom % 4) != 0;
      bit word = $urandom % 2;
      logic [5:0] a = 6'($urandom);
      logic [31:0] w = $urandom;
      if (word) a[1:0] = 2'b00;
      if (a[5:4] == 2'd1 && ($urandom % 2)) w = w & 32'h0F0F_0F0F;
      online_cnt_i = 4'(onl);
      op(tag_of(we, a, w), we, a, word, w, r);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule